// File: doc/BRIEF.md
# Grouped Maskable Interrupt Aggregator

This block gathers interrupt events from three source groups and drives one active-low interrupt line to a host. The groups are general-purpose pin edges, bus-interface pin edges and single-cycle event pulses from an on-chip keyboard-scan engine. Each group has a status register that its events set and a mask register that enables them. Both pin groups also have a per-pin edge-select register.

A read-only summary register gives one bit per group, and a bit is 1 when that group has a set status bit whose mask bit is also 1. An interrupt handler reads the summary first to find the group. It then reads that group's status and mask and clears the bits it has handled by writing ones. Registers are reached through a simple synchronous port with address, write data, write enable and combinational read data.

Top module: `irq_group_agg`

## Requirements
- R1: A general-purpose pin edge of the selected polarity sets that pin's bit in the pin status register (address 0). The polarity comes from the pin's bit in the edge-select register (address 2), where 0 selects rising and 1 selects falling. A pin change driven between clock edges is readable as status after the third following rising clock edge, and not after the second.
- R2: A pin transition of the polarity that is not selected leaves the status unchanged.
- R3: Bus-interface pins form a separate group with their own status (address 3), mask (address 4) and edge select (address 5). They follow the same edge rules and the same timing as R1.
- R4: A one-cycle high pulse on a keyboard event input sets the matching bit of the keyboard status register (address 6) at the next rising clock edge. The keyboard mask is at address 7.
- R5: `irq_n` is 0 exactly when some status bit is 1 and the matching mask bit is 1. A mask bit of 1 enables its source, and a status bit under a 0 mask leaves `irq_n` at 1.
- R6: The summary register (address 8) reads bit 0 for the pin group, bit 1 for the bus group and bit 2 for the keyboard group. Each bit is 1 when that group has any status bit that is set and also enabled.
- R7: Writing 1 to a status bit clears it, and writing 0 to a status bit leaves it unchanged.
- R8: When an event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Reset clears all status, mask and edge-select registers, so `irq_n` reads 1 and every register reads 0.
- R10: Writes to the summary register or to an unused address change nothing, and those unused addresses read 0.
- R11: Mask and edge-select registers read back the value written, truncated to the group width. Bits above the group width read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_pin | input | GPIO_W | Asynchronous general-purpose pins |
| bus_pin | input | BUS_W | Asynchronous bus-interface pins |
| key_evt | input | KEY_W | Synchronous keyboard event pulses |
| we | input | 1 | Register write enable |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Register read data, combinational from addr |
| irq_n | output | 1 | Active-low host interrupt |

## Verification
A vector table writes each mask and edge-select register with values that overflow the group width. It also writes to the summary and unused addresses, which tells proper truncation and read-only decoding apart from plain storage. Directed pin tests try rising and falling transitions under both edge-select settings, sampling after both the second and the third clock edge. This separates correct polarity and synchronizer latency from early or inverted detection. Keyboard pulses are sent alone, together with a clear of the same bit, and together with a clear of a different bit, which separates set-over-clear priority from a plain clear. Masked and unmasked status and a reset during activity show whether the interrupt line and the summary follow the mask.

// File: rtl/irq_group_agg.sv
module irq_group_agg #(
  parameter int GPIO_W = 8,
  parameter int BUS_W  = 3,
  parameter int KEY_W  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GPIO_W-1:0] gpio_pin,
  input  logic [BUS_W-1:0]  bus_pin,
  input  logic [KEY_W-1:0]  key_evt,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_n
);

  localparam int PIN_W = GPIO_W + BUS_W;
  localparam logic [ADDR_W-1:0] A_GST = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_GMK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_GES = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_BST = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_BMK = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_BES = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_KST = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_KMK = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_SUM = ADDR_W'(8);

  logic [GPIO_W-1:0] gpio_st, gpio_mk, gpio_es, gpio_ev;
  logic [BUS_W-1:0]  bus_st, bus_mk, bus_es, bus_ev;
  logic [KEY_W-1:0]  key_st, key_mk;
  logic [PIN_W-1:0]  sync1, sync2, prev, esel, edge_ev;
  logic [2:0]        grp;

  // edge detection: two-flop synchronizer, then previous-value register
  assign esel    = {bus_es, gpio_es};
  assign edge_ev = (sync2 & ~prev & ~esel) | (~sync2 & prev & esel);
  assign gpio_ev = edge_ev[GPIO_W-1:0];
  assign bus_ev  = edge_ev[PIN_W-1:GPIO_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= {bus_pin, gpio_pin};
      sync2 <= sync1;
      prev  <= sync2;
    end

  wire wr_gst = we && addr == A_GST;
  wire wr_bst = we && addr == A_BST;
  wire wr_kst = we && addr == A_KST;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gpio_st <= '0; gpio_mk <= '0; gpio_es <= '0;
      bus_st  <= '0; bus_mk  <= '0; bus_es  <= '0;
      key_st  <= '0; key_mk  <= '0;
    end else begin
      // set has priority over write-1-to-clear
      gpio_st <= (gpio_st & ~(wr_gst ? wdata[GPIO_W-1:0] : '0)) | gpio_ev;
      bus_st  <= (bus_st  & ~(wr_bst ? wdata[BUS_W-1:0]  : '0)) | bus_ev;
      key_st  <= (key_st  & ~(wr_kst ? wdata[KEY_W-1:0]  : '0)) | key_evt;
      if (we && addr == A_GMK) gpio_mk <= wdata[GPIO_W-1:0];
      if (we && addr == A_GES) gpio_es <= wdata[GPIO_W-1:0];
      if (we && addr == A_BMK) bus_mk  <= wdata[BUS_W-1:0];
      if (we && addr == A_BES) bus_es  <= wdata[BUS_W-1:0];
      if (we && addr == A_KMK) key_mk  <= wdata[KEY_W-1:0];
    end

  assign grp   = {|(key_st & key_mk), |(bus_st & bus_mk), |(gpio_st & gpio_mk)};
  assign irq_n = ~|grp;

  always_comb
    case (addr)
      A_GST:   rdata = DATA_W'(gpio_st);
      A_GMK:   rdata = DATA_W'(gpio_mk);
      A_GES:   rdata = DATA_W'(gpio_es);
      A_BST:   rdata = DATA_W'(bus_st);
      A_BMK:   rdata = DATA_W'(bus_mk);
      A_BES:   rdata = DATA_W'(bus_es);
      A_KST:   rdata = DATA_W'(key_st);
      A_KMK:   rdata = DATA_W'(key_mk);
      A_SUM:   rdata = DATA_W'(grp);
      default: rdata = '0;
    endcase

  p_only_evt_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((gpio_st & ~$past(gpio_st) & ~$past(gpio_ev)) == '0));
  p_key_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((key_st & $past(key_evt)) == $past(key_evt)));
  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_mk == '0 && bus_mk == '0 && key_mk == '0) |-> irq_n);
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_gst |=> ((gpio_st & $past(wdata[GPIO_W-1:0]) & ~$past(gpio_ev)) == '0));
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((gpio_st & $past(gpio_ev)) == $past(gpio_ev)));
  p_reset_quiet_r9: assert property (@(posedge clk)
    $rose(rst_n) |-> irq_n);
  p_summary_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_SUM) |=> ($stable(gpio_mk) && $stable(bus_mk) && $stable(key_mk)));

endmodule

// File: tb/sim_irq_group_agg.sv
`timescale 1ns/1ps
module sim_irq_group_agg;
  logic       clk = 0, rst_n = 0;
  logic [7:0] gpio_pin = '0;
  logic [2:0] bus_pin = '0;
  logic [3:0] key_evt = '0;
  logic       we = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  irq_group_agg u0 (.clk(clk), .rst_n(rst_n), .gpio_pin(gpio_pin), .bus_pin(bus_pin),
    .key_evt(key_evt), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

  // {addr, wdata, expected readback}
  localparam int NV = 9;
  localparam logic [19:0] VEC [NV] = '{
    {4'h1, 8'hA5, 8'hA5}, {4'h2, 8'h3C, 8'h3C}, {4'h4, 8'hFF, 8'h07},
    {4'h5, 8'hFA, 8'h02}, {4'h7, 8'hFF, 8'h0F}, {4'h8, 8'hFF, 8'h00},
    {4'hF, 8'hFF, 8'h00}, {4'h9, 8'h55, 8'h00}, {4'h1, 8'h00, 8'h00}};

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int a = 0; a < 10; a++) chk_reg("R9 reset reg", 4'(a), 8'h00);
    chk("R9 reset irq_n", {7'b0, irq_n}, 8'h01);
    rst_n = 1;
    @(negedge clk);

    // R11 R10: register write/readback table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][19:16], VEC[i][15:8]);
      chk_reg("R11/R10 table", VEC[i][19:16], VEC[i][7:0]);
    end
    wr(4'h2, 8'h00); wr(4'h4, 8'h00); wr(4'h5, 8'h00); wr(4'h7, 8'h00);
    chk("R5 masks off irq_n", {7'b0, irq_n}, 8'h01);

    // R1: rising edge on pin 2, latency
    wr(4'h1, 8'h04);
    @(negedge clk); gpio_pin[2] = 1;
    repeat (2) @(negedge clk);
    chk_reg("R1 not yet after 2 edges", 4'h0, 8'h00);
    @(negedge clk);
    chk_reg("R1 rising sets", 4'h0, 8'h04);
    chk("R5 irq asserted", {7'b0, irq_n}, 8'h00);
    chk_reg("R6 summary gpio", 4'h8, 8'h01);

    // R7: write 0 keeps, write 1 clears
    wr(4'h0, 8'hFB);
    chk_reg("R7 write0 keeps", 4'h0, 8'h04);
    wr(4'h0, 8'h04);
    chk_reg("R7 write1 clears", 4'h0, 8'h00);
    chk("R5 irq released", {7'b0, irq_n}, 8'h01);

    // R2: falling edge ignored under rising select
    @(negedge clk); gpio_pin[2] = 0;
    repeat (4) @(negedge clk);
    chk_reg("R2 falling ignored", 4'h0, 8'h00);

    // R1 falling select; R2 rising ignored under falling select
    wr(4'h2, 8'h04);
    @(negedge clk); gpio_pin[2] = 1;
    repeat (4) @(negedge clk);
    chk_reg("R2 rising ignored", 4'h0, 8'h00);
    @(negedge clk); gpio_pin[2] = 0;
    repeat (3) @(negedge clk);
    chk_reg("R1 falling sets", 4'h0, 8'h04);

    // R5: masked status leaves irq high
    wr(4'h1, 8'h00);
    chk("R5 masked irq_n", {7'b0, irq_n}, 8'h01);
    chk_reg("R6 summary masked", 4'h8, 8'h00);
    wr(4'h0, 8'hFF);

    // R3: bus group
    wr(4'h4, 8'h02);
    @(negedge clk); bus_pin[1] = 1;
    repeat (2) @(negedge clk);
    chk_reg("R3 not yet", 4'h3, 8'h00);
    @(negedge clk);
    chk_reg("R3 bus rising sets", 4'h3, 8'h02);
    chk_reg("R3 gpio untouched", 4'h0, 8'h00);
    chk_reg("R6 summary bus", 4'h8, 8'h02);
    wr(4'h3, 8'h02);
    chk_reg("R3 bus cleared", 4'h3, 8'h00);

    // R4: keyboard pulse
    wr(4'h7, 8'h08);
    @(negedge clk); key_evt = 4'h8;
    @(negedge clk); key_evt = 4'h0;
    chk_reg("R4 key sets", 4'h6, 8'h08);
    chk_reg("R6 summary key", 4'h8, 8'h04);
    chk("R5 key irq", {7'b0, irq_n}, 8'h00);

    // R8: set wins over clear; other bit in same write clears
    @(negedge clk); key_evt = 4'h1;
    @(negedge clk); key_evt = 4'h1; we = 1; addr = 4'h6; wdata = 8'h09;
    @(negedge clk); key_evt = 4'h0; we = 0;
    chk_reg("R8 set wins / R7 clear other", 4'h6, 8'h01);
    chk("R5 bit0 unmasked irq_n", {7'b0, irq_n}, 8'h01);

    // R9: reset during activity
    wr(4'h7, 8'h0F);
    chk("R5 irq before reset", {7'b0, irq_n}, 8'h00);
    @(negedge clk); rst_n = 0;
    #1;
    chk("R9 irq after reset", {7'b0, irq_n}, 8'h01);
    chk_reg("R9 key st", 4'h6, 8'h00);
    chk_reg("R9 key mask", 4'h7, 8'h00);
    chk_reg("R9 gpio esel", 4'h2, 8'h00);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    finish_run();
  end
endmodule